// File: doc/BRIEF.md
# Register Window Overflow Detector

Before a call frame claims more physical registers, the processor must check that the register groups it is about to use are not still held by an older live frame. This block makes that check. The register file is split into groups of four registers. A start vector holds one bit per group, and a set bit marks the first group of a live frame. A request names the current window base and how many groups ahead will be used (0 to 3). The block looks ahead of the base, with wraparound, for the nearest set start bit inside that reach.

When the nearest live frame lies inside the reach, the block reports an overflow. It gives the forward rotation that brings the window onto that frame, the old base and program counter the handler must keep, and a strobe that sets exception mode. From the two start bits that follow the live frame it also decides whether the frame to spill holds 4, 8 or 12 registers. The surrounding pipeline moves the window, spills the registers and dispatches the handler.

A request is a single-cycle `chk_valid` pulse. There is no back-pressure: a request is taken in every cycle in which it is raised. Its result appears exactly one cycle later, for one cycle only, marked by `res_valid`, and the consumer must capture it then.

Top module: `wovf_detector`

## Requirements
- R1: A request made while `ovf_enable` is 0 or `exc_mode` is 1 produces no overflow: `set_exc_mode`=0, `exc_sel`=0 and `rotate_by`=0.
- R2: An enabled request tests the start bits at groups (base+n) mod G for n=1..`req_count`, where G = `NUM_AREGS`/4. The smallest such n with a set bit is chosen. The bit at the base itself is never tested.
- R3: When no start bit is set in those groups, including when `req_count`=0, the result has `set_exc_mode`=0, `exc_sel`=0 and `rotate_by`=0.
- R4: On an overflow, `rotate_by` equals the chosen n.
- R5: On an overflow, `set_exc_mode`=1, `old_base` equals the request's `win_base`, and `saved_pc` equals the request's `cur_pc`. These two outputs are 0 otherwise.
- R6: With m = (base+n) mod G, `exc_sel` is 3'b001 (4-register spill) if start bit (m+1) mod G is set. Otherwise it is 3'b010 (8-register spill) if start bit (m+2) mod G is set. Otherwise it is 3'b100 (12-register spill). `exc_sel` is 0 when there is no overflow.
- R7: `res_valid` and all results appear in the cycle after a `chk_valid` pulse and last one cycle. In any other cycle every output is 0, so back-to-back requests give back-to-back results.
- R8: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | One-cycle check request |
| win_base | input | BASE_W | Current window base, in groups |
| win_start | input | GROUPS | Live-frame start bit per group |
| req_count | input | CNT_W | Groups ahead to be used (0..MAX_REQ) |
| ovf_enable | input | 1 | Overflow detection enable |
| exc_mode | input | 1 | Exception mode currently active |
| cur_pc | input | PC_W | Program counter of the requesting instruction |
| res_valid | output | 1 | Result present this cycle |
| rotate_by | output | CNT_W | Forward window rotation on overflow |
| old_base | output | BASE_W | Window base to save on overflow |
| set_exc_mode | output | 1 | Strobe: enter exception mode |
| saved_pc | output | PC_W | Program counter to save on overflow |
| exc_sel | output | 3 | One-hot spill size: 001=4, 010=8, 100=12 |

## Verification
Every result is due on the clock edge after the request edge, because a single register rank stands between the request inputs and all outputs. The bench drives a request on a falling edge and samples the outputs on the next falling edge, which lies half a period after the edge that loads them. It checks again one falling edge later that the outputs have returned to zero. A back-to-back case raises requests on two consecutive cycles and samples each result one cycle after its own request.

// File: rtl/wovf_pkg.sv
`timescale 1ns/1ps
package wovf_pkg;
  // One-hot spill size reported on an overflow
  typedef enum logic [2:0] {
    OVF_NONE = 3'b000,
    OVF_4    = 3'b001,
    OVF_8    = 3'b010,
    OVF_12   = 3'b100
  } ovf_kind_e;
endpackage

// File: rtl/wovf_scan.sv
`timescale 1ns/1ps
// Parallel circular look-ahead: nearest live frame within reach
module wovf_scan #(
  parameter int GROUPS  = 16,
  parameter int BASE_W  = 4,
  parameter int CNT_W   = 2,
  parameter int MAX_REQ = 3
) (
  input  logic [BASE_W-1:0] base,
  input  logic [GROUPS-1:0] start,
  input  logic [CNT_W-1:0]  count,
  output logic              hit,
  output logic [CNT_W-1:0]  offset,
  output logic [BASE_W-1:0] frame
);
  logic [MAX_REQ:1]  cand;
  logic [BASE_W-1:0] idx [MAX_REQ:1];

  for (genvar k = 1; k <= MAX_REQ; k++) begin : g_off
    // group count is a power of two, so the adder wraps for free
    assign idx[k]  = base + BASE_W'(k);
    assign cand[k] = start[idx[k]] && (CNT_W'(k) <= count);
  end

  always_comb begin
    hit    = 1'b0;
    offset = '0;
    frame  = '0;
    // walk from the far end so the nearest candidate wins
    for (int k = MAX_REQ; k >= 1; k--) begin
      if (cand[k]) begin
        hit    = 1'b1;
        offset = CNT_W'(k);
        frame  = idx[k];
      end
    end
  end
endmodule

// File: rtl/wovf_classify.sv
`timescale 1ns/1ps
// Spill size from the two start bits beyond the live frame
module wovf_classify
  import wovf_pkg::*;
#(
  parameter int GROUPS = 16,
  parameter int BASE_W = 4
) (
  input  logic [GROUPS-1:0] start,
  input  logic [BASE_W-1:0] frame,
  output ovf_kind_e         kind
);
  logic [BASE_W-1:0] next1, next2;

  assign next1 = frame + BASE_W'(1);
  assign next2 = frame + BASE_W'(2);

  always_comb begin
    if (start[next1])      kind = OVF_4;
    else if (start[next2]) kind = OVF_8;
    else                   kind = OVF_12;
  end
endmodule

// File: rtl/wovf_detector.sv
`timescale 1ns/1ps
module wovf_detector
  import wovf_pkg::*;
#(
  parameter int NUM_AREGS = 64,
  parameter int PC_W      = 32,
  parameter int MAX_REQ   = 3,
  localparam int GROUPS   = NUM_AREGS / 4,
  localparam int BASE_W   = $clog2(GROUPS),
  localparam int CNT_W    = $clog2(MAX_REQ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [BASE_W-1:0] win_base,
  input  logic [GROUPS-1:0] win_start,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              ovf_enable,
  input  logic              exc_mode,
  input  logic [PC_W-1:0]   cur_pc,
  output logic              res_valid,
  output logic [CNT_W-1:0]  rotate_by,
  output logic [BASE_W-1:0] old_base,
  output logic              set_exc_mode,
  output logic [PC_W-1:0]   saved_pc,
  output logic [2:0]        exc_sel
);
  logic              scan_hit;
  logic [CNT_W-1:0]  scan_off;
  logic [BASE_W-1:0] scan_frame;
  ovf_kind_e         frame_kind;
  logic              armed, fire;

  wovf_scan #(
    .GROUPS(GROUPS), .BASE_W(BASE_W), .CNT_W(CNT_W), .MAX_REQ(MAX_REQ)
  ) u_scan (
    .base(win_base), .start(win_start), .count(req_count),
    .hit(scan_hit), .offset(scan_off), .frame(scan_frame)
  );

  wovf_classify #(
    .GROUPS(GROUPS), .BASE_W(BASE_W)
  ) u_class (
    .start(win_start), .frame(scan_frame), .kind(frame_kind)
  );

  assign armed = ovf_enable && !exc_mode;
  assign fire  = chk_valid && armed && scan_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      rotate_by    <= '0;
      old_base     <= '0;
      set_exc_mode <= 1'b0;
      saved_pc     <= '0;
      exc_sel      <= '0;
    end else begin
      res_valid    <= chk_valid;
      set_exc_mode <= fire;
      rotate_by    <= fire ? scan_off : '0;
      old_base     <= fire ? win_base : '0;
      saved_pc     <= fire ? cur_pc   : '0;
      exc_sel      <= fire ? frame_kind : OVF_NONE;
    end
  end
endmodule

// File: rtl/wovf_detector_chk.sv
`timescale 1ns/1ps
module wovf_detector_chk #(
  parameter int BASE_W = 4,
  parameter int GROUPS = 16,
  parameter int CNT_W  = 2,
  parameter int PC_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_valid,
  input logic [BASE_W-1:0] win_base,
  input logic [CNT_W-1:0]  req_count,
  input logic              ovf_enable,
  input logic              exc_mode,
  input logic [PC_W-1:0]   cur_pc,
  input logic              res_valid,
  input logic [CNT_W-1:0]  rotate_by,
  input logic [BASE_W-1:0] old_base,
  input logic              set_exc_mode,
  input logic [PC_W-1:0]   saved_pc,
  input logic [2:0]        exc_sel
);
  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && (!ovf_enable || exc_mode) |=> !set_exc_mode && rotate_by == '0);

  assert_reach_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rotate_by <= $past(req_count));

  assert_rot_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (set_exc_mode == (rotate_by != '0)));

  assert_context_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> (!set_exc_mode ||
                   (saved_pc == $past(cur_pc) && old_base == $past(win_base))));

  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_exc_mode |-> $countones(exc_sel) == 1);

  assert_sel_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !set_exc_mode |-> exc_sel == 3'b000);

  assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> res_valid);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !res_valid && !set_exc_mode && saved_pc == '0);
endmodule

bind wovf_detector wovf_detector_chk #(
  .BASE_W(BASE_W), .GROUPS(GROUPS), .CNT_W(CNT_W), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .win_base(win_base),
  .req_count(req_count), .ovf_enable(ovf_enable), .exc_mode(exc_mode),
  .cur_pc(cur_pc), .res_valid(res_valid), .rotate_by(rotate_by),
  .old_base(old_base), .set_exc_mode(set_exc_mode), .saved_pc(saved_pc),
  .exc_sel(exc_sel)
);

// File: tb/wovf_detector_tb.sv
`timescale 1ns/1ps
module wovf_detector_tb;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0;
  logic [3:0]  win_base = '0;
  logic [15:0] win_start = '0;
  logic [1:0]  req_count = '0;
  logic        ovf_enable = 1'b0;
  logic        exc_mode = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        res_valid, set_exc_mode;
  logic [1:0]  rotate_by;
  logic [3:0]  old_base;
  logic [31:0] saved_pc;
  logic [2:0]  exc_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wovf_detector u_dut (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .win_base(win_base),
    .win_start(win_start), .req_count(req_count), .ovf_enable(ovf_enable),
    .exc_mode(exc_mode), .cur_pc(cur_pc), .res_valid(res_valid),
    .rotate_by(rotate_by), .old_base(old_base), .set_exc_mode(set_exc_mode),
    .saved_pc(saved_pc), .exc_sel(exc_sel)
  );

  // {base, start, count, enable, excmode, exp_rot, exp_sel}
  localparam logic [28:0] VEC [0:NV-1] = '{
    {4'd0,  16'h0002, 2'd3, 1'b1, 1'b0, 2'd1, 3'b100}, // R6 12-reg
    {4'd0,  16'h000A, 2'd3, 1'b1, 1'b0, 2'd1, 3'b010}, // R6 8-reg
    {4'd0,  16'h0006, 2'd3, 1'b1, 1'b0, 2'd1, 3'b001}, // R6 4-reg
    {4'd5,  16'h0100, 2'd3, 1'b1, 1'b0, 2'd3, 3'b100}, // R2 far reach
    {4'd5,  16'h0100, 2'd2, 1'b1, 1'b0, 2'd0, 3'b000}, // R3 out of reach
    {4'd14, 16'h0003, 2'd3, 1'b1, 1'b0, 2'd2, 3'b001}, // R2 wrap scan
    {4'd15, 16'h0005, 2'd3, 1'b1, 1'b0, 2'd1, 3'b010}, // R6 wrap
    {4'd3,  16'h0030, 2'd3, 1'b0, 1'b0, 2'd0, 3'b000}, // R1 disabled
    {4'd3,  16'h0030, 2'd3, 1'b1, 1'b1, 2'd0, 3'b000}, // R1 excmode
    {4'd3,  16'h0030, 2'd3, 1'b1, 1'b0, 2'd1, 3'b001}, // R4
    {4'd3,  16'h0040, 2'd0, 1'b1, 1'b0, 2'd0, 3'b000}, // R3 count 0
    {4'd13, 16'hC000, 2'd3, 1'b1, 1'b0, 2'd1, 3'b001}, // R2 nearest wins
    {4'd13, 16'h8001, 2'd3, 1'b1, 1'b0, 2'd2, 3'b001}, // R6 m+1 wraps
    {4'd12, 16'h4001, 2'd3, 1'b1, 1'b0, 2'd2, 3'b010}, // R6 m+2 wraps
    {4'd7,  16'h0080, 2'd3, 1'b1, 1'b0, 2'd0, 3'b000}  // R2 base not tested
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [28:0] v, input logic [31:0] pc);
    win_base   = v[28:25];
    win_start  = v[24:9];
    req_count  = v[8:7];
    ovf_enable = v[6];
    exc_mode   = v[5];
    cur_pc     = pc;
    chk_valid  = 1'b1;
  endtask

  task automatic expect_result(input logic [28:0] v, input logic [31:0] pc);
    logic hit;
    hit = (v[2:0] != 3'b000);
    check("R7", "res_valid", 32'(res_valid), 32'd1);
    check("R4", "rotate_by", 32'(rotate_by), 32'(v[4:3]));
    check("R6", "exc_sel", 32'(exc_sel), 32'(v[2:0]));
    check("R5", "set_exc_mode", 32'(set_exc_mode), 32'(hit));
    check("R5", "old_base", 32'(old_base), hit ? 32'(v[28:25]) : 32'd0);
    check("R5", "saved_pc", saved_pc, hit ? pc : 32'd0);
  endtask

  task automatic expect_idle(input string req);
    check(req, "idle res_valid", 32'(res_valid), 32'd0);
    check(req, "idle exc_sel", 32'(exc_sel), 32'd0);
    check(req, "idle set_exc_mode", 32'(set_exc_mode), 32'd0);
    check(req, "idle rotate_by", 32'(rotate_by), 32'd0);
    check(req, "idle saved_pc", saved_pc, 32'd0);
    check(req, "idle old_base", 32'(old_base), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8: reset holds outputs at zero even with a request present
    repeat (2) @(negedge clk);
    drive(VEC[2], 32'hDEAD_0000);
    @(negedge clk);
    expect_idle("R8");
    chk_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_idle("R8");

    // table walk: result due one cycle after the request, gone after two
    for (int i = 0; i < NV; i++) begin
      logic [31:0] pc;
      pc = 32'h1000_0000 + 32'(i) * 32'd4;
      drive(VEC[i], pc);
      @(negedge clk);
      chk_valid = 1'b0;
      expect_result(VEC[i], pc);
      @(negedge clk);
      expect_idle("R7");
    end

    // R7: back-to-back requests each answered on the following cycle
    drive(VEC[0], 32'hA000_0000);
    @(negedge clk);
    expect_result(VEC[0], 32'hA000_0000);
    drive(VEC[8], 32'hA000_0004);
    @(negedge clk);
    expect_result(VEC[8], 32'hA000_0004);
    drive(VEC[13], 32'hA000_0008);
    @(negedge clk);
    chk_valid = 1'b0;
    expect_result(VEC[13], 32'hA000_0008);
    @(negedge clk);
    expect_idle("R7");

    // R7: enabled hit pattern held without a request gives nothing
    drive(VEC[1], 32'hB000_0000);
    chk_valid = 1'b0;
    @(negedge clk);
    expect_idle("R7");

    // R8: reset in the middle drops a pending result
    drive(VEC[3], 32'hC000_0000);
    @(negedge clk);
    chk_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    expect_idle("R8");
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule